// File: doc/BRIEF.md
# Run-Mode Clock Source Switch Controller

This block picks which of three oscillators clocks a small controller-class device: a primary oscillator (optionally followed by a PLL), a slow secondary oscillator, and an internal RC oscillator. Software writes a 2-bit source code and an idle-enable bit through a single write strobe. Only that strobe changes the stored bits. The controller then moves the device onto the requested source without disturbing the clock it is currently running on.

Every oscillator is seen inside the controller's own clock domain as a one-cycle tick per edge. When the primary is requested, its enable is raised and a start-up counter counts primary ticks. If the PLL is in use, a further lock interval is counted after that. Until the count is done the old source keeps clocking the device. Changeover goes through a two-stage gate per source, clocked by that source's ticks. A source's gate only starts to open when every other gate has fully closed, so two sources never drive the output together and no pulse is cut short. The ready flag follows the primary's gate, and the primary is switched off once it is neither requested nor driving.

Top module: `clk_src_switch`

## Requirements
- R1: While reset is held and in the first cycle after it, `sel_q` is 00, `idle_q` is 0, `active_src` is 000, `osc_ready` is 0 and `pri_osc_en` is 1.
- R2: After reset the primary is engaged (`active_src` = 001) no sooner than `OST_CYCLES` primary ticks and no later than six cycles after that when ticks arrive every cycle; `osc_ready` is then 1.
- R3: Source code `1x` (bit 1 set) selects the RC oscillator (`active_src` = 100) whatever bit 0 holds.
- R4: Source code 01 selects the secondary oscillator (`active_src` = 010) and raises `sec_osc_en`.
- R5: `active_src` is one-hot or zero, and a source is only engaged after a cycle in which no source was engaged.
- R6: While the primary is starting up, the previously active source keeps driving `active_src` and `sys_tick`.
- R7: With `pll_en` high, engaging the primary takes at least `OST_CYCLES + PLL_CYCLES` primary ticks after its enable rises.
- R8: Once a switch away from the primary is complete, `pri_osc_en` and `osc_ready` are 0.
- R9: `rc_osc_en` stays 1 after leaving the RC source while `wdt_en` or `fscm_en` is 1, and drops when both are 0.
- R10: `sel_q` and `idle_q` change only in the cycle after `cfg_wr` and then hold the written values; a clock switch never modifies them.
- R11: A write that arrives while a switch is pending retargets the sequence to the newly written source, and the abandoned primary start-up ends with `pri_osc_en` low.
- R12: `sys_tick` pulses exactly on the ticks of the engaged source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for source code and idle bit |
| cfg_sel | input | 2 | Requested source code (00 primary, 01 secondary, 1x RC) |
| cfg_idle | input | 1 | Idle-enable bit to store |
| pll_en | input | 1 | Primary path uses the PLL |
| wdt_en | input | 1 | Watchdog enabled (keeps RC running) |
| fscm_en | input | 1 | Fail-safe monitor enabled (keeps RC running) |
| tick_pri | input | 1 | One-cycle pulse per primary oscillator edge |
| tick_sec | input | 1 | One-cycle pulse per secondary oscillator edge |
| tick_rc | input | 1 | One-cycle pulse per RC oscillator edge |
| sel_q | output | 2 | Stored source code |
| idle_q | output | 1 | Stored idle-enable bit |
| pri_osc_en | output | 1 | Primary oscillator enable |
| sec_osc_en | output | 1 | Secondary oscillator enable |
| rc_osc_en | output | 1 | RC oscillator enable |
| osc_ready | output | 1 | Primary oscillator is ready and driving the device |
| active_src | output | 3 | One-hot engaged source {RC, secondary, primary} |
| sys_tick | output | 1 | Ticks of the engaged source (device clock) |

## Verification
If the start-up counter is wrong, it shows up as the primary engaging too early or too late. With ticks every cycle the bench times that edge to within a few cycles of `OST_CYCLES` (plus `PLL_CYCLES`). A broken gate interlock shows as two bits of `active_src` set at once, or as a new source engaging with no empty cycle before it. The bench monitor sees either fault at the edge where it occurs. Stale wanted-source state shows as the wrong source engaging after a retarget, or as `pri_osc_en` or `rc_osc_en` left high after the switch has settled, and a settle check finds it within a few hundred cycles.

// File: rtl/clk_src_pkg.sv
// Shared types for the clock source switch controller.
package clk_src_pkg;
    localparam int NSRC = 3;

    // Bit positions inside the one-hot source vectors.
    typedef enum int {
        SRC_PRI = 0,
        SRC_SEC = 1,
        SRC_RC  = 2
    } src_idx_e;

    // Decode the 2-bit source code: bit 1 set means RC, bit 0 is then ignored.
    function automatic logic [NSRC-1:0] code_to_onehot(input logic [1:0] code);
        if (code[1])      return 3'b100;
        else if (code[0]) return 3'b010;
        else              return 3'b001;
    endfunction
endpackage

// File: rtl/ckss_startup.sv
// Primary start-up timer: counts primary ticks while the primary is enabled,
// first the oscillator start-up interval, then (if pll_en) the PLL lock interval.
// Assumes tick is a one-cycle pulse per primary edge in the clk domain.
module ckss_startup #(
    parameter int OST_CYCLES = 1024,
    parameter int PLL_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic tick,
    input  logic pll_en,
    output logic done
);
    localparam int TOTAL = OST_CYCLES + PLL_CYCLES;
    localparam int CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Pick the target count for the current PLL setting.
    always_comb limit = pll_en ? CW'(TOTAL) : CW'(OST_CYCLES);

    // Count primary ticks; restart whenever the oscillator is switched off.
    always_ff @(posedge clk) begin
        if (!rst_n || !osc_en) cnt <= '0;
        else if (tick && (cnt < limit)) cnt <= cnt + 1'b1;
    end

    assign done = osc_en && (cnt >= limit);

    // R7: the counter never runs past the longest interval.
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(TOTAL));
endmodule

// File: rtl/ckss_handoff.sv
// Per-source two-stage gate: req is sampled on this source's ticks, so the gate
// opens or closes only on this source's edges, two edges after req changes.
// Assumes tick keeps pulsing while the source is enabled.
module ckss_handoff (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    output logic gate,
    output logic busy
);
    logic s1, s2;

    // Shift the request through two stages on the source's own ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else if (tick) begin
            s1 <= req;
            s2 <= s1;
        end
    end

    assign gate = s2;
    assign busy = s1 | s2;
endmodule

// File: rtl/ckss_seq.sv
// Sequencer: holds the wanted source. The wanted source moves to the target
// only once the target is ready, so the old source keeps running meanwhile.
// Assumes the secondary and RC sources are ready whenever requested.
module ckss_seq
    import clk_src_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] target_oh,
    input  logic            pri_ready,
    output logic [NSRC-1:0] want
);
    logic target_ready;

    // Primary is ready after its timer; the other sources are ready at once.
    always_comb target_ready = target_oh[SRC_PRI] ? pri_ready : 1'b1;

    // Commit the target as wanted once it is ready; a new target re-arms this.
    always_ff @(posedge clk) begin
        if (!rst_n) want <= '0;
        else if (target_ready) want <= target_oh;
    end
endmodule

// File: rtl/clk_src_switch.sv
// Run-mode clock source switch controller (top).
// Stores the source code and idle bit, times primary start-up, and hands the
// device clock from one source to another without overlap or short pulses.
// Assumes each oscillator is presented as one-cycle ticks in the clk domain.
module clk_src_switch
    import clk_src_pkg::*;
#(
    parameter int OST_CYCLES = 1024,
    parameter int PLL_CYCLES = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_sel,
    input  logic       cfg_idle,
    input  logic       pll_en,
    input  logic       wdt_en,
    input  logic       fscm_en,
    input  logic       tick_pri,
    input  logic       tick_sec,
    input  logic       tick_rc,
    output logic [1:0] sel_q,
    output logic       idle_q,
    output logic       pri_osc_en,
    output logic       sec_osc_en,
    output logic       rc_osc_en,
    output logic       osc_ready,
    output logic [2:0] active_src,
    output logic       sys_tick
);
    logic [NSRC-1:0] target_oh;
    logic [NSRC-1:0] want;
    logic [NSRC-1:0] gate;
    logic [NSRC-1:0] busy;
    logic [NSRC-1:0] ticks;
    logic            pri_ready;

    // Software-visible bits change only on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 2'b00;
            idle_q <= 1'b0;
        end else if (cfg_wr) begin
            sel_q  <= cfg_sel;
            idle_q <= cfg_idle;
        end
    end

    // Decode the stored code into the target source.
    always_comb target_oh = code_to_onehot(sel_q);

    // Gather ticks in source order.
    always_comb ticks = {tick_rc, tick_sec, tick_pri};

    // Oscillator enables: on while requested, wanted or still gated.
    always_comb begin
        pri_osc_en = target_oh[SRC_PRI] | want[SRC_PRI] | busy[SRC_PRI];
        sec_osc_en = target_oh[SRC_SEC] | want[SRC_SEC] | busy[SRC_SEC];
        rc_osc_en  = target_oh[SRC_RC]  | want[SRC_RC]  | busy[SRC_RC]
                   | wdt_en | fscm_en;
    end

    ckss_startup #(
        .OST_CYCLES(OST_CYCLES),
        .PLL_CYCLES(PLL_CYCLES)
    ) u_startup (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_en (pri_osc_en),
        .tick   (tick_pri),
        .pll_en (pll_en),
        .done   (pri_ready)
    );

    ckss_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .target_oh (target_oh),
        .pri_ready (pri_ready),
        .want      (want)
    );

    // One gate per source; a gate may start opening only when all others are idle.
    for (genvar i = 0; i < NSRC; i++) begin : g_gate
        logic others_busy;
        always_comb others_busy = |(busy & ~(NSRC'(1) << i));
        ckss_handoff u_handoff (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (ticks[i]),
            .req   (want[i] & ~others_busy),
            .gate  (gate[i]),
            .busy  (busy[i])
        );
    end

    assign active_src = gate;
    assign osc_ready  = gate[SRC_PRI];
    assign sys_tick   = |(gate & ticks);

    // R5: never more than one engaged source.
    assert_onehot_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active_src));

    // R5: a source engages only after a cycle with nothing engaged.
    assert_break_before_make_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_src != 3'b000 && active_src != $past(active_src))
        |-> $past(active_src) == 3'b000);

    // R2: the primary engages only after its start-up timer has finished.
    assert_pri_after_startup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate[SRC_PRI]) |-> pri_ready);

    // R10: stored bits are stable without a write strobe.
    assert_cfg_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(sel_q) && $stable(idle_q)));
endmodule

// File: tb/clk_src_switch_bench.sv
// Scoreboard bench: driver pushes expected engaged sources, monitor pops them.
module clk_src_switch_bench;
    localparam int OST = 64;
    localparam int PLL = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'b00;
    logic       cfg_idle = 1'b0;
    logic       pll_en = 1'b0;
    logic       wdt_en = 1'b0;
    logic       fscm_en = 1'b0;
    logic       tick_pri = 1'b0;
    logic       tick_sec = 1'b0;
    logic       tick_rc = 1'b0;
    logic [1:0] sel_q;
    logic       idle_q, pri_osc_en, sec_osc_en, rc_osc_en, osc_ready, sys_tick;
    logic [2:0] active_src;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;
    logic [2:0] exp_q[$];
    logic [2:0] last_act = 3'b000;

    clk_src_switch #(.OST_CYCLES(OST), .PLL_CYCLES(PLL)) u_clk_src_switch (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_idle(cfg_idle), .pll_en(pll_en), .wdt_en(wdt_en), .fscm_en(fscm_en),
        .tick_pri(tick_pri), .tick_sec(tick_sec), .tick_rc(tick_rc),
        .sel_q(sel_q), .idle_q(idle_q), .pri_osc_en(pri_osc_en),
        .sec_osc_en(sec_osc_en), .rc_osc_en(rc_osc_en), .osc_ready(osc_ready),
        .active_src(active_src), .sys_tick(sys_tick));

    always #5 clk = ~clk;

    // Oscillator ticks: primary every cycle, RC every 2nd, secondary every 5th.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        tick_pri <= 1'b1;
        tick_rc  <= (cyc % 2) == 0;
        tick_sec <= (cyc % 5) == 0;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compare each newly engaged source against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones(active_src) > 1) begin
                fails++;
                $display("FAIL R5 overlap actual=%0d expected=onehot", active_src);
            end
            if (active_src != last_act && active_src != 3'b000) begin
                if (exp_q.size() == 0) chk(0, "R5 unexpected engage", active_src, 0);
                else begin
                    logic [2:0] e;
                    e = exp_q.pop_front();
                    chk(active_src == e, "R3/R4/R11 engaged source", active_src, e);
                end
            end
            last_act <= active_src;
        end
    end

    task automatic write_cfg(input logic [1:0] s, input logic idl);
        @(negedge clk);
        cfg_sel = s; cfg_idle = idl; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic request(input logic [1:0] s, input logic idl, input logic [2:0] e);
        exp_q.push_back(e);
        write_cfg(s, idl);
    endtask

    task automatic wait_act(input logic [2:0] e, output int n);
        n = 0;
        while (active_src != e && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        int st, tk;
        exp_q.push_back(3'b001);
        repeat (3) @(negedge clk);
        chk(sel_q == 2'b00 && idle_q == 0, "R1 cfg reset", {idle_q, sel_q}, 0);
        chk(active_src == 3'b000 && osc_ready == 0, "R1 nothing engaged", active_src, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pri_osc_en == 1, "R1 primary enabled", pri_osc_en, 1);
        wait_act(3'b001, n);
        n = n + 1;
        chk(n >= OST && n <= OST + 6, "R2 start-up latency", n, OST);
        chk(osc_ready == 1, "R2 ready flag", osc_ready, 1);

        // R3: code 11 picks RC, bit 0 ignored.
        request(2'b11, 1'b0, 3'b100);
        wait_act(3'b100, n);
        chk(active_src == 3'b100, "R3 RC engaged", active_src, 3'b100);
        chk(pri_osc_en == 0 && osc_ready == 0, "R8 primary off", {pri_osc_en, osc_ready}, 0);
        chk(sel_q == 2'b11, "R10 code kept", sel_q, 3);

        // R6/R7: back to primary through the PLL, RC keeps driving meanwhile.
        pll_en = 1'b1;
        request(2'b00, 1'b1, 3'b001);
        repeat (40) @(negedge clk);
        chk(active_src == 3'b100, "R6 old source holds", active_src, 3'b100);
        st = 0; tk = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            st += sys_tick; tk += tick_rc;
        end
        chk(st == tk && st > 0, "R6 old source ticks", st, tk);
        wait_act(3'b001, n);
        n = n + 62;
        chk(n >= OST + PLL, "R7 PLL lock interval", n, OST + PLL);
        chk(idle_q == 1 && osc_ready == 1, "R10 idle bit kept", idle_q, 1);

        // R4: secondary source.
        request(2'b01, 1'b1, 3'b010);
        wait_act(3'b010, n);
        chk(active_src == 3'b010 && sec_osc_en == 1, "R4 secondary engaged", active_src, 2);
        repeat (3) @(negedge clk);
        chk(pri_osc_en == 0 && osc_ready == 0, "R8 primary off again", pri_osc_en, 0);
        st = 0; tk = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            st += sys_tick; tk += tick_sec;
        end
        chk(st == tk && st == 10, "R12 sys_tick follows secondary", st, tk);

        // R9: RC kept alive by watchdog / monitor enables.
        request(2'b10, 1'b1, 3'b100);
        wait_act(3'b100, n);
        wdt_en = 1'b1;
        request(2'b01, 1'b1, 3'b010);
        wait_act(3'b010, n);
        repeat (5) @(negedge clk);
        chk(rc_osc_en == 1, "R9 RC held by watchdog", rc_osc_en, 1);
        wdt_en = 1'b0; fscm_en = 1'b1;
        @(negedge clk);
        chk(rc_osc_en == 1, "R9 RC held by monitor", rc_osc_en, 1);
        fscm_en = 1'b0;
        @(negedge clk);
        chk(rc_osc_en == 0, "R9 RC released", rc_osc_en, 0);

        // R11: retarget while the primary is still starting.
        write_cfg(2'b00, 1'b0);
        repeat (8) @(negedge clk);
        chk(active_src == 3'b010 && pri_osc_en == 1, "R11 pending, old holds", active_src, 2);
        request(2'b11, 1'b0, 3'b100);
        wait_act(3'b100, n);
        repeat (4) @(negedge clk);
        chk(active_src == 3'b100 && pri_osc_en == 0, "R11 retargeted to RC", {pri_osc_en, active_src}, 3'b100);

        // R10: inputs without a strobe are ignored.
        @(negedge clk);
        cfg_sel = 2'b00; cfg_idle = 1'b1;
        repeat (200) @(negedge clk);
        chk(sel_q == 2'b11 && idle_q == 0, "R10 no strobe no change", {idle_q, sel_q}, 3);
        chk(active_src == 3'b100, "R10 source unchanged", active_src, 4);
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule